// File: doc/BRIEF.md
# Dual Free-List Receive Descriptor Engine

This block is the hardware half of a descriptor-ring receive path. Software keeps two free-buffer rings stocked. Each entry in these rings names an empty host buffer by address, capacity and a tag. One ring holds small buffers and the other holds large buffers. When a frame arrives, the engine compares its length with a small-buffer limit, picks one of the two rings, and takes the oldest entry from it. It then issues a one-cycle buffer-fill transaction that stands in for the DMA write. Finally it writes a completion entry into a single shared completion ring. The completion entry carries the same tag, the frame status, the frame length and which ring supplied the buffer.

Software reads completions from the head of the completion ring. It can watch every ring's read and write pointers. It services two interrupt causes, which are latched in a status register and gated by a mask. The first cause is "completion written". The second is "a free ring is running low".

Frames are lost in two cases, and each case is handled differently. If the completion ring is full, the frame is discarded quietly: no buffer is taken, no completion is written and no interrupt is raised. If the chosen free ring is empty, the frame is discarded and a saturating drop counter advances. Each ring's capacity comes from a 2-bit size code, and its pointers wrap at that capacity.

Top module: `rx_desc_engine`

## Requirements
- R1: A synchronous reset sets all six ring pointers, the interrupt status, the drop counter, `cqValid` and `fillValid` to zero.
- R2: A frame whose length is at most SMALL_MAX (1536) draws from the small ring (completion `cqSel`=0). A longer frame draws from the large ring (`cqSel`=1). Only the read pointer of the chosen ring advances, by one.
- R3: The clock edge that accepts a frame writes a completion carrying the popped entry's tag, the frame status and the frame length. In the cycle after that edge, `fillValid` is high with the popped entry's address, buffer size and tag. Completions leave the ring in arrival order.
- R4: A ring with size code c holds BASE_DEPTH<<c entries (4, 8, 16 or 32 with the default of 4). Its pointers return to 0 after the last slot.
- R5: A push into a full free ring is ignored and leaves its write pointer unchanged. A pop of an empty completion ring is ignored and leaves its read pointer unchanged.
- R6: A frame that arrives while the completion ring is full has no effect. No free entry is taken, no fill is issued, no completion is written, status bit 0 does not set and the drop counter does not move. This check takes priority over the free-ring check.
- R7: A frame whose chosen free ring is empty is discarded. The drop counter rises by one and saturates at its maximum. No fill or completion is produced, and the other free ring is not touched.
- R8: Status bit 0 (receive data) sets on the edge that writes a completion.
- R9: Status bit 1 (free low) sets on every edge at which either free ring holds fewer than LOW_THRESH (2) entries. This includes the first edge after reset, when both rings are empty.
- R10: A `statusRd` pulse clears the latched status bits at that edge. A cause that sets at the same edge stays set.
- R11: `irqOut` is high exactly when some status bit is set and its `irqMask` bit is 1. With a zero mask it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smSizeCode | input | 2 | Size code of the small free ring |
| lgSizeCode | input | 2 | Size code of the large free ring |
| cqSizeCode | input | 2 | Size code of the completion ring |
| smPush | input | 1 | Post an entry to the small free ring |
| smAddr | input | ADDR_W | Buffer address of the posted small entry |
| smBufSize | input | LEN_W | Buffer capacity of the posted small entry |
| smId | input | ID_W | Tag of the posted small entry |
| lgPush | input | 1 | Post an entry to the large free ring |
| lgAddr | input | ADDR_W | Buffer address of the posted large entry |
| lgBufSize | input | LEN_W | Buffer capacity of the posted large entry |
| lgId | input | ID_W | Tag of the posted large entry |
| frmValid | input | 1 | A frame arrives this cycle |
| frmLen | input | LEN_W | Frame length in bytes |
| frmStat | input | STAT_W | Frame status |
| fillValid | output | 1 | Buffer-fill transaction strobe |
| fillAddr | output | ADDR_W | Address of the buffer being filled |
| fillBufSize | output | LEN_W | Capacity of the buffer being filled |
| fillLen | output | LEN_W | Bytes written into the buffer |
| fillId | output | ID_W | Tag of the buffer being filled |
| cqPop | input | 1 | Software takes the head completion |
| cqValid | output | 1 | Completion ring not empty |
| cqId | output | ID_W | Tag of the head completion |
| cqStat | output | STAT_W | Status of the head completion |
| cqLen | output | LEN_W | Length of the head completion |
| cqSel | output | 1 | Source ring of the head completion (0 small, 1 large) |
| smRdPtr | output | PTR_W | Small ring read pointer |
| smWrPtr | output | PTR_W | Small ring write pointer |
| lgRdPtr | output | PTR_W | Large ring read pointer |
| lgWrPtr | output | PTR_W | Large ring write pointer |
| cqRdPtr | output | PTR_W | Completion ring read pointer |
| cqWrPtr | output | PTR_W | Completion ring write pointer |
| statusRd | input | 1 | Status read; clears latched bits |
| irqMask | input | 2 | Interrupt enables (bit 0 receive data, bit 1 free low) |
| irqStatus | output | 2 | Latched interrupt causes |
| irqOut | output | 1 | Interrupt request |
| dropCount | output | DROP_W | Frames lost to an empty free ring |

## Verification
The assertions assume three things about the inputs. Reset is held for at least one clock edge before normal operation. The size codes stay fixed while any ring holds entries. Only one frame is offered per cycle.

The stimulus respects all three. The size codes are tied to constants, reset is held for several cycles at the start, and frames are presented as single-cycle pulses driven on the falling edge. The completion ring is drained or filled on purpose, so that its full and empty corners each appear in a known cycle.

// File: rtl/rxeng_pkg.sv
`timescale 1ns/1ps
package rxeng_pkg;
  // Strobes from the control unit to the datapath for one cycle.
  typedef struct packed {
    logic popSmall;  // take the head entry of the small free ring
    logic popLarge;  // take the head entry of the large free ring
    logic pushCpl;   // write a completion and issue a fill
    logic dropOvf;   // frame lost to an empty free ring
  } rxStrobes_t;

  localparam int IRQ_W       = 2;
  localparam int IRQ_RXDATA  = 0;
  localparam int IRQ_FREELOW = 1;
endpackage

// File: rtl/rxeng_ring.sv
`timescale 1ns/1ps
// Circular descriptor store whose capacity is chosen at run time by a size code.
// BASE_DEPTH must be a power of two.
module rxeng_ring #(
  parameter int W          = 8,
  parameter int BASE_DEPTH = 4,
  parameter int PTR_W      = $clog2(BASE_DEPTH * 8)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sizeCode,
  input  logic             push,
  input  logic [W-1:0]     pushData,
  input  logic             pop,
  output logic [W-1:0]     headData,
  output logic [PTR_W-1:0] rdPtr,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W:0]   count,
  output logic             full,
  output logic             empty
);
  localparam int MAX_DEPTH = BASE_DEPTH * 8;

  logic [W-1:0]     mem [MAX_DEPTH];
  logic [PTR_W:0]   depth;
  logic [PTR_W-1:0] ptrMask;
  logic             doPush;
  logic             doPop;

  always_comb begin
    depth    = (PTR_W+1)'(BASE_DEPTH) << sizeCode;
    ptrMask  = depth[PTR_W-1:0] - PTR_W'(1);
    full     = (count == depth);
    empty    = (count == '0);
    doPush   = push && !full;
    doPop    = pop && !empty;
    headData = mem[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr + PTR_W'(1)) & ptrMask;
      if (doPop)  rdPtr <= (rdPtr + PTR_W'(1)) & ptrMask;
      count <= count + (PTR_W+1)'(doPush) - (PTR_W+1)'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/rxeng_datapath.sv
`timescale 1ns/1ps
// Holds the three rings, builds completion entries and drives the fill strobe.
module rxeng_datapath
  import rxeng_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int ID_W       = 8,
  parameter int STAT_W     = 4,
  parameter int BASE_DEPTH = 4,
  parameter int PTR_W      = $clog2(BASE_DEPTH * 8)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  rxStrobes_t                    stb,
  input  logic [1:0][1:0]               fqSizeCode,
  input  logic [1:0]                    fqPush,
  input  logic [1:0][ADDR_W-1:0]        fqAddr,
  input  logic [1:0][LEN_W-1:0]         fqBufSize,
  input  logic [1:0][ID_W-1:0]          fqId,
  input  logic [1:0]                    cqSizeCode,
  input  logic                          cqPop,
  input  logic [LEN_W-1:0]              frmLen,
  input  logic [STAT_W-1:0]             frmStat,
  output logic [1:0][PTR_W-1:0]         fqRdPtr,
  output logic [1:0][PTR_W-1:0]         fqWrPtr,
  output logic [1:0][PTR_W:0]           fqCount,
  output logic [1:0]                    fqEmpty,
  output logic [PTR_W-1:0]              cqRdPtr,
  output logic [PTR_W-1:0]              cqWrPtr,
  output logic                          cqFull,
  output logic                          cqValid,
  output logic [ID_W-1:0]               cqId,
  output logic [STAT_W-1:0]             cqStat,
  output logic [LEN_W-1:0]              cqLen,
  output logic                          cqSel,
  output logic                          fillValid,
  output logic [ADDR_W-1:0]             fillAddr,
  output logic [LEN_W-1:0]              fillBufSize,
  output logic [LEN_W-1:0]              fillLen,
  output logic [ID_W-1:0]               fillId
);
  localparam int FD_W = ADDR_W + LEN_W + ID_W;     // free entry: {addr, size, tag}
  localparam int CD_W = ID_W + STAT_W + LEN_W + 1; // completion: {tag, stat, len, sel}

  logic [1:0]            fqPop;
  logic [1:0][FD_W-1:0]  fqHead;
  logic [1:0]            fqFull;
  logic [FD_W-1:0]       selDesc;
  logic [ADDR_W-1:0]     selAddr;
  logic [LEN_W-1:0]      selSize;
  logic [ID_W-1:0]       selId;
  logic [CD_W-1:0]       cplData;
  logic [CD_W-1:0]       cqHead;
  logic [PTR_W:0]        cqCount;
  logic                  cqEmpty;

  assign fqPop = {stb.popLarge, stb.popSmall};

  for (genvar q = 0; q < 2; q++) begin : g_free
    rxeng_ring #(
      .W(FD_W), .BASE_DEPTH(BASE_DEPTH), .PTR_W(PTR_W)
    ) u_ring (
      .clk      (clk),
      .rst      (rst),
      .sizeCode (fqSizeCode[q]),
      .push     (fqPush[q]),
      .pushData ({fqAddr[q], fqBufSize[q], fqId[q]}),
      .pop      (fqPop[q]),
      .headData (fqHead[q]),
      .rdPtr    (fqRdPtr[q]),
      .wrPtr    (fqWrPtr[q]),
      .count    (fqCount[q]),
      .full     (fqFull[q]),
      .empty    (fqEmpty[q])
    );
  end

  always_comb begin
    selDesc = stb.popLarge ? fqHead[1] : fqHead[0];
    {selAddr, selSize, selId} = selDesc;
    cplData = {selId, frmStat, frmLen, stb.popLarge};
  end

  rxeng_ring #(
    .W(CD_W), .BASE_DEPTH(BASE_DEPTH), .PTR_W(PTR_W)
  ) u_cpl (
    .clk      (clk),
    .rst      (rst),
    .sizeCode (cqSizeCode),
    .push     (stb.pushCpl),
    .pushData (cplData),
    .pop      (cqPop),
    .headData (cqHead),
    .rdPtr    (cqRdPtr),
    .wrPtr    (cqWrPtr),
    .count    (cqCount),
    .full     (cqFull),
    .empty    (cqEmpty)
  );

  always_comb begin
    cqValid = !cqEmpty;
    {cqId, cqStat, cqLen, cqSel} = cqHead;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fillValid   <= 1'b0;
      fillAddr    <= '0;
      fillBufSize <= '0;
      fillLen     <= '0;
      fillId      <= '0;
    end else begin
      fillValid <= stb.pushCpl;
      if (stb.pushCpl) begin
        fillAddr    <= selAddr;
        fillBufSize <= selSize;
        fillLen     <= frmLen;
        fillId      <= selId;
      end
    end
  end
endmodule

// File: rtl/rxeng_control.sv
`timescale 1ns/1ps
// Chooses the free ring, decides accept or drop, and keeps interrupt state.
module rxeng_control
  import rxeng_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int PTR_W      = 5,
  parameter int SMALL_MAX  = 1536,
  parameter int LOW_THRESH = 2,
  parameter int DROP_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frmValid,
  input  logic [LEN_W-1:0]      frmLen,
  input  logic [1:0]            fqEmpty,
  input  logic [1:0][PTR_W:0]   fqCount,
  input  logic                  cqFull,
  input  logic                  statusRd,
  input  logic [IRQ_W-1:0]      irqMask,
  output rxStrobes_t            stb,
  output logic [IRQ_W-1:0]      irqStatus,
  output logic                  irqOut,
  output logic [DROP_W-1:0]     dropCount
);
  logic             wantLarge;
  logic             selEmpty;
  logic             freeLow;
  logic [IRQ_W-1:0] irqSet;

  always_comb begin
    stb       = '0;
    wantLarge = frmLen > LEN_W'(SMALL_MAX);
    selEmpty  = wantLarge ? fqEmpty[1] : fqEmpty[0];
    // A full completion ring wins: the frame vanishes without side effects.
    if (frmValid && !cqFull) begin
      if (selEmpty) begin
        stb.dropOvf = 1'b1;
      end else begin
        stb.popSmall = !wantLarge;
        stb.popLarge = wantLarge;
        stb.pushCpl  = 1'b1;
      end
    end
  end

  always_comb begin
    freeLow = (fqCount[0] < (PTR_W+1)'(LOW_THRESH)) ||
              (fqCount[1] < (PTR_W+1)'(LOW_THRESH));
    irqSet              = '0;
    irqSet[IRQ_RXDATA]  = stb.pushCpl;
    irqSet[IRQ_FREELOW] = freeLow;
    irqOut              = |(irqStatus & irqMask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqStatus <= '0;
      dropCount <= '0;
    end else begin
      irqStatus <= (statusRd ? '0 : irqStatus) | irqSet;
      if (stb.dropOvf && (dropCount != '1)) dropCount <= dropCount + DROP_W'(1);
    end
  end
endmodule

// File: rtl/rx_desc_engine.sv
`timescale 1ns/1ps
module rx_desc_engine
  import rxeng_pkg::*;
#(
  parameter int  ADDR_W     = 32,
  parameter int  LEN_W      = 16,
  parameter int  ID_W       = 8,
  parameter int  STAT_W     = 4,
  parameter int  BASE_DEPTH = 4,
  parameter int  SMALL_MAX  = 1536,
  parameter int  LOW_THRESH = 2,
  parameter int  DROP_W     = 8,
  localparam int PTR_W      = $clog2(BASE_DEPTH * 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        smSizeCode,
  input  logic [1:0]        lgSizeCode,
  input  logic [1:0]        cqSizeCode,
  input  logic              smPush,
  input  logic [ADDR_W-1:0] smAddr,
  input  logic [LEN_W-1:0]  smBufSize,
  input  logic [ID_W-1:0]   smId,
  input  logic              lgPush,
  input  logic [ADDR_W-1:0] lgAddr,
  input  logic [LEN_W-1:0]  lgBufSize,
  input  logic [ID_W-1:0]   lgId,
  input  logic              frmValid,
  input  logic [LEN_W-1:0]  frmLen,
  input  logic [STAT_W-1:0] frmStat,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [LEN_W-1:0]  fillBufSize,
  output logic [LEN_W-1:0]  fillLen,
  output logic [ID_W-1:0]   fillId,
  input  logic              cqPop,
  output logic              cqValid,
  output logic [ID_W-1:0]   cqId,
  output logic [STAT_W-1:0] cqStat,
  output logic [LEN_W-1:0]  cqLen,
  output logic              cqSel,
  output logic [PTR_W-1:0]  smRdPtr,
  output logic [PTR_W-1:0]  smWrPtr,
  output logic [PTR_W-1:0]  lgRdPtr,
  output logic [PTR_W-1:0]  lgWrPtr,
  output logic [PTR_W-1:0]  cqRdPtr,
  output logic [PTR_W-1:0]  cqWrPtr,
  input  logic              statusRd,
  input  logic [1:0]        irqMask,
  output logic [1:0]        irqStatus,
  output logic              irqOut,
  output logic [DROP_W-1:0] dropCount
);
  rxStrobes_t            stb;
  logic [1:0][PTR_W-1:0] fqRdPtr;
  logic [1:0][PTR_W-1:0] fqWrPtr;
  logic [1:0][PTR_W:0]   fqCount;
  logic [1:0]            fqEmpty;
  logic                  cqFull;

  rxeng_control #(
    .LEN_W(LEN_W), .PTR_W(PTR_W), .SMALL_MAX(SMALL_MAX),
    .LOW_THRESH(LOW_THRESH), .DROP_W(DROP_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .frmValid  (frmValid),
    .frmLen    (frmLen),
    .fqEmpty   (fqEmpty),
    .fqCount   (fqCount),
    .cqFull    (cqFull),
    .statusRd  (statusRd),
    .irqMask   (irqMask),
    .stb       (stb),
    .irqStatus (irqStatus),
    .irqOut    (irqOut),
    .dropCount (dropCount)
  );

  rxeng_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ID_W(ID_W), .STAT_W(STAT_W),
    .BASE_DEPTH(BASE_DEPTH), .PTR_W(PTR_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .fqSizeCode  ({lgSizeCode, smSizeCode}),
    .fqPush      ({lgPush, smPush}),
    .fqAddr      ({lgAddr, smAddr}),
    .fqBufSize   ({lgBufSize, smBufSize}),
    .fqId        ({lgId, smId}),
    .cqSizeCode  (cqSizeCode),
    .cqPop       (cqPop),
    .frmLen      (frmLen),
    .frmStat     (frmStat),
    .fqRdPtr     (fqRdPtr),
    .fqWrPtr     (fqWrPtr),
    .fqCount     (fqCount),
    .fqEmpty     (fqEmpty),
    .cqRdPtr     (cqRdPtr),
    .cqWrPtr     (cqWrPtr),
    .cqFull      (cqFull),
    .cqValid     (cqValid),
    .cqId        (cqId),
    .cqStat      (cqStat),
    .cqLen       (cqLen),
    .cqSel       (cqSel),
    .fillValid   (fillValid),
    .fillAddr    (fillAddr),
    .fillBufSize (fillBufSize),
    .fillLen     (fillLen),
    .fillId      (fillId)
  );

  assign smRdPtr = fqRdPtr[0];
  assign smWrPtr = fqWrPtr[0];
  assign lgRdPtr = fqRdPtr[1];
  assign lgWrPtr = fqWrPtr[1];
endmodule

// File: rtl/rxeng_checker.sv
`timescale 1ns/1ps
module rxeng_checker #(
  parameter int PTR_W  = 5,
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fillValid,
  input logic              cqValid,
  input logic [1:0]        irqStatus,
  input logic [1:0]        irqMask,
  input logic              irqOut,
  input logic [DROP_W-1:0] dropCount,
  input logic [PTR_W-1:0]  smRdPtr,
  input logic [PTR_W-1:0]  smWrPtr,
  input logic [PTR_W-1:0]  lgRdPtr,
  input logic [PTR_W-1:0]  lgWrPtr,
  input logic [PTR_W-1:0]  cqRdPtr,
  input logic [PTR_W-1:0]  cqWrPtr
);
  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= rst;

  always @(negedge clk) begin
    if (rstSeen) begin
      AST_RESET_STATE: assert (smRdPtr == '0 && smWrPtr == '0 && lgRdPtr == '0 &&
                               lgWrPtr == '0 && cqRdPtr == '0 && cqWrPtr == '0 &&
                               irqStatus == '0 && dropCount == '0 &&
                               !fillValid && !cqValid)
        else $error("reset state wrong"); // R1
    end
  end

  AST_FILL_HAS_CPL: assert property (@(posedge clk) disable iff (rst)
    fillValid |-> cqValid) else $error("fill without completion"); // R3

  AST_CQ_PTR_ONLY_ON_FILL: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(cqWrPtr)) |-> fillValid) else $error("completion write without fill"); // R6

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (dropCount == $past(dropCount) || dropCount == $past(dropCount) + 1'b1))
    else $error("drop counter jump"); // R7

  AST_RXDATA_WITH_FILL: assert property (@(posedge clk) disable iff (rst)
    fillValid |-> irqStatus[0]) else $error("receive-data cause missing"); // R8

  AST_FREELOW_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !rst) |=> irqStatus[1]) else $error("free-low cause missing after reset"); // R9

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (irqMask == '0) |-> !irqOut) else $error("interrupt with zero mask"); // R11
endmodule

bind rx_desc_engine rxeng_checker #(.PTR_W(PTR_W), .DROP_W(DROP_W)) u_checker (
  .clk       (clk),
  .rst       (rst),
  .fillValid (fillValid),
  .cqValid   (cqValid),
  .irqStatus (irqStatus),
  .irqMask   (irqMask),
  .irqOut    (irqOut),
  .dropCount (dropCount),
  .smRdPtr   (smRdPtr),
  .smWrPtr   (smWrPtr),
  .lgRdPtr   (lgRdPtr),
  .lgWrPtr   (lgWrPtr),
  .cqRdPtr   (cqRdPtr),
  .cqWrPtr   (cqWrPtr)
);

// File: tb/tb_rx_desc_engine.sv
`timescale 1ns/1ps
module tb_rx_desc_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  smSizeCode = 2'd0, lgSizeCode = 2'd1, cqSizeCode = 2'd0;
  logic        smPush = 0, lgPush = 0;
  logic [31:0] smAddr = 0, lgAddr = 0;
  logic [15:0] smBufSize = 0, lgBufSize = 0;
  logic [7:0]  smId = 0, lgId = 0;
  logic        frmValid = 0;
  logic [15:0] frmLen = 0;
  logic [3:0]  frmStat = 0;
  logic        cqPop = 0, statusRd = 0;
  logic [1:0]  irqMask = 0;
  logic        fillValid, cqValid, cqSel, irqOut;
  logic [31:0] fillAddr;
  logic [15:0] fillBufSize, fillLen, cqLen;
  logic [7:0]  fillId, cqId, dropCount;
  logic [3:0]  cqStat;
  logic [1:0]  irqStatus;
  logic [4:0]  smRdPtr, smWrPtr, lgRdPtr, lgWrPtr, cqRdPtr, cqWrPtr;

  always #2.5 clk = ~clk;

  rx_desc_engine dut (
    .clk(clk), .rst(rst), .smSizeCode(smSizeCode), .lgSizeCode(lgSizeCode),
    .cqSizeCode(cqSizeCode), .smPush(smPush), .smAddr(smAddr), .smBufSize(smBufSize),
    .smId(smId), .lgPush(lgPush), .lgAddr(lgAddr), .lgBufSize(lgBufSize), .lgId(lgId),
    .frmValid(frmValid), .frmLen(frmLen), .frmStat(frmStat), .fillValid(fillValid),
    .fillAddr(fillAddr), .fillBufSize(fillBufSize), .fillLen(fillLen), .fillId(fillId),
    .cqPop(cqPop), .cqValid(cqValid), .cqId(cqId), .cqStat(cqStat), .cqLen(cqLen),
    .cqSel(cqSel), .smRdPtr(smRdPtr), .smWrPtr(smWrPtr), .lgRdPtr(lgRdPtr),
    .lgWrPtr(lgWrPtr), .cqRdPtr(cqRdPtr), .cqWrPtr(cqWrPtr), .statusRd(statusRd),
    .irqMask(irqMask), .irqStatus(irqStatus), .irqOut(irqOut), .dropCount(dropCount)
  );

  typedef struct packed {
    logic [15:0] len;
    logic [3:0]  stat;
    logic        sel;
    logic [7:0]  id;
    logic [31:0] addr;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{16'd64,    4'h1, 1'b0, 8'h10, 32'h0000_1000},
    '{16'd1536,  4'h2, 1'b0, 8'h11, 32'h0000_1100},
    '{16'd1537,  4'h3, 1'b1, 8'h20, 32'h0000_8000},
    '{16'd9000,  4'h4, 1'b1, 8'h21, 32'h0000_9000},
    '{16'd26000, 4'h5, 1'b1, 8'h22, 32'h0000_A000},
    '{16'd100,   4'h6, 1'b0, 8'h12, 32'h0000_1200}
  };

  int  nChecks = 0;
  int  nFail   = 0;
  bit  finished = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pushSmall(input logic [31:0] a, input logic [7:0] id);
    smPush = 1; smAddr = a; smBufSize = 16'h0600; smId = id;
    @(negedge clk); smPush = 0;
  endtask

  task automatic pushLarge(input logic [31:0] a, input logic [7:0] id);
    lgPush = 1; lgAddr = a; lgBufSize = 16'h6800; lgId = id;
    @(negedge clk); lgPush = 0;
  endtask

  task automatic sendFrame(input logic [15:0] l, input logic [3:0] s);
    frmValid = 1; frmLen = l; frmStat = s;
    @(negedge clk); frmValid = 0;
  endtask

  task automatic popCpl();
    cqPop = 1; @(negedge clk); cqPop = 0;
  endtask

  task automatic readStatus();
    statusRd = 1; @(negedge clk); statusRd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "pointers", {smRdPtr, smWrPtr, lgRdPtr, lgWrPtr, cqRdPtr, cqWrPtr}, 32'h0);
    chk("R1", "status/drop/valids", {irqStatus, dropCount, fillValid, cqValid}, 32'h0);
    rst = 0;
    @(negedge clk);
    chk("R9", "free-low after reset", irqStatus[1], 1'b1);

    for (int i = 0; i < 4; i++) pushSmall(32'h1000 + 32'h100 * i, 8'h10 + 8'(i));
    chk("R4", "small wptr wraps at depth 4", smWrPtr, 5'd0);
    pushSmall(32'hDEAD, 8'hEE);
    chk("R5", "push into full ring ignored", smWrPtr, 5'd0);
    for (int i = 0; i < 6; i++) pushLarge(32'h8000 + 32'h1000 * i, 8'h20 + 8'(i));
    chk("R4", "large wptr", lgWrPtr, 5'd6);
    readStatus();
    chk("R9", "no free-low with rings stocked", irqStatus, 2'b00);

    for (int v = 0; v < NVEC; v++) begin
      sendFrame(VECS[v].len, VECS[v].stat);
      chk("R3", "fill valid", fillValid, 1'b1);
      chk("R3", "fill id", fillId, VECS[v].id);
      chk("R3", "fill addr", fillAddr, VECS[v].addr);
      chk("R3", "fill len", fillLen, VECS[v].len);
      chk("R3", "fill bufsize", fillBufSize, VECS[v].sel ? 32'h6800 : 32'h0600);
      chk("R3", "cpl valid", cqValid, 1'b1);
      chk("R3", "cpl id", cqId, VECS[v].id);
      chk("R3", "cpl stat", cqStat, VECS[v].stat);
      chk("R3", "cpl len", cqLen, VECS[v].len);
      chk("R2", "cpl source ring", cqSel, VECS[v].sel);
      chk("R8", "receive-data cause", irqStatus[0], 1'b1);
      popCpl();
    end
    chk("R2", "small rptr", smRdPtr, 5'd3);
    chk("R2", "large rptr", lgRdPtr, 5'd3);
    chk("R4", "cq wptr wraps", cqWrPtr, 5'd2);
    chk("R9", "free-low with one small entry", irqStatus[1], 1'b1);

    readStatus();
    chk("R10", "read clears rx bit, low re-sets", irqStatus, 2'b10);
    statusRd = 1;
    sendFrame(16'd2000, 4'h7);
    statusRd = 0;
    chk("R10", "set wins over read clear", irqStatus[0], 1'b1);
    chk("R2", "large frame tag", fillId, 8'h23);
    popCpl();

    irqMask = 2'b00; @(negedge clk);
    chk("R11", "zero mask quiet", irqOut, 1'b0);
    irqMask = 2'b10; @(negedge clk);
    chk("R11", "free-low enabled", irqOut, 1'b1);
    irqMask = 2'b00;

    sendFrame(16'd50, 4'h8);
    chk("R3", "last small tag", fillId, 8'h13);
    popCpl();
    sendFrame(16'd50, 4'h9);
    chk("R7", "drop count", dropCount, 8'd1);
    chk("R7", "no fill", fillValid, 1'b0);
    chk("R7", "no completion", cqValid, 1'b0);
    chk("R7", "large ring untouched", lgRdPtr, 5'd4);
    chk("R7", "cq wptr unchanged", cqWrPtr, 5'd0);

    for (int i = 0; i < 4; i++) pushSmall(32'h2000 + 32'h100 * i, 8'h30 + 8'(i));
    for (int i = 0; i < 4; i++) sendFrame(16'd200 + 16'(i), 4'(i));
    chk("R4", "cq full wptr wraps", cqWrPtr, 5'd0);
    readStatus();
    sendFrame(16'd4000, 4'hA);
    chk("R6", "no fill when cq full", fillValid, 1'b0);
    chk("R6", "large ring not consumed", lgRdPtr, 5'd4);
    chk("R6", "drop count unchanged", dropCount, 8'd1);
    chk("R6", "no receive-data cause", irqStatus[0], 1'b0);
    chk("R6", "cq wptr unchanged", cqWrPtr, 5'd0);

    for (int i = 0; i < 4; i++) begin
      chk("R3", "order id", cqId, 8'h30 + 8'(i));
      chk("R3", "order len", cqLen, 16'd200 + 16'(i));
      popCpl();
    end
    chk("R5", "cq empty", cqValid, 1'b0);
    popCpl();
    chk("R5", "pop of empty ignored", cqRdPtr, 5'd0);

    pushLarge(32'hC000, 8'h26);
    pushLarge(32'hD000, 8'h27);
    chk("R4", "large wptr wraps at depth 8", lgWrPtr, 5'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule